// File: doc/BRIEF.md
# Configurable UART with Internal Loopback

This block is an asynchronous serial transceiver whose behaviour is set by one 8-bit control register. The register switches the block on, routes the transmit stream straight back into the receiver, inverts the transmit line, picks 8-bit or 9-bit characters, adds even or odd parity, selects how line idle is detected, and enables marking of address characters. The bit rate comes from the `OVS_DIV` parameter. A 16x sample tick occurs every `OVS_DIV` clocks, so one bit lasts `16*OVS_DIV` clocks.

Software loads one character at a time through a write strobe into a single holding slot. Two flags report progress. "Empty" means the slot is free. "Done" means the slot is free and no frame is being shifted out. Received characters appear as a one-cycle valid pulse, together with the data word and the error and mark flags. An idle pulse reports that the line has gone quiet after a character.

Top module: `uart_loop_xcvr`

## Requirements
- R1: After reset the control register reads 0. Its bit layout, from bit 7 down to bit 0, is: loopback, enable, transmit invert, 9-bit length, address-mark enable, idle-after-stop, parity enable, odd parity. A written value reads back unchanged.
- R2: While enable is 0, `tx_empty` and `tx_done` are 1 and `tx_irq` is 0. Any `tx_wr` is dropped, so no frame is sent after the block is enabled.
- R3: With 9-bit length at 0, a frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts `16*OVS_DIV` clocks.
- R4: With 9-bit length at 1, the frame carries 9 data bits, taken from `tx_wdata[8:0]`, LSB first.
- R5: With parity enabled, the last data position of the frame is replaced by a parity bit. That bit is the XOR of the bits below it for even parity (odd-parity bit 0). It is the inverse of that XOR for odd parity (odd-parity bit 1).
- R6: With transmit invert at 1, every level on `txd` is inverted: idle, start, data, parity and stop. This holds in every mode, including when the block is disabled.
- R7: With loopback at 1, the `rxd` pin is ignored. The uninverted transmit stream feeds the receiver, and `txd` stays at the idle level (1 XOR invert).
- R8: The receiver rebuilds the character into `rx_data`, with the parity position kept and bit 8 reading 0 for 8-bit characters. `rx_valid` is a one-cycle pulse. `rx_frame_err` is set when the stop bit reads 0. `rx_par_err` is set when parity is enabled and the check fails.
- R9: Each bit value is the majority of 16x samples 7, 8 and 9 after the falling edge. A low pulse shorter than half a bit is rejected as a false start and produces no character.
- R10: A write accepted with the holding slot free clears `tx_empty` on the next clock. `tx_empty` returns to 1 when the frame starts. `tx_done` is 0 from then until the stop bit ends. `tx_done` implies `tx_empty`. `tx_irq` equals enable AND `tx_empty`.
- R11: `rx_addr_mark` is 1 for a received character only when 9-bit length is 1, parity is 0, address-mark enable is 1 and received bit 8 is 1.
- R12: After each character, `rx_idle` pulses once when the line has been high for one full frame time. With idle-after-stop at 0, high samples inside the character count. With idle-after-stop at 1, counting starts only after the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| tx_wr | input | 1 | Transmit character write strobe |
| tx_wdata | input | 9 | Transmit character |
| tx_empty | output | 1 | Holding slot free |
| tx_done | output | 1 | Slot free and shifter idle |
| tx_irq | output | 1 | Transmit interrupt request |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin |
| rx_valid | output | 1 | One-cycle pulse: character received |
| rx_data | output | 9 | Received character |
| rx_frame_err | output | 1 | Stop bit read as 0 |
| rx_par_err | output | 1 | Parity check failed |
| rx_addr_mark | output | 1 | Ninth bit flagged as address mark |
| rx_idle | output | 1 | One-cycle pulse: idle line after a character |

## Verification
The assertions check relations that must hold on every cycle: the forced flags and idle `txd` level while disabled, the idle `txd` level in loopback with either polarity, `tx_done` implying `tx_empty`, and `rx_valid` lasting one cycle. Frame contents, bit timing, parity values, majority rejection of glitches, error detection, address marking and the two idle-counting modes show only through the bench's scenarios. The bench sweeps every length and parity combination with several data patterns. It decodes `txd` at bit centres and checks the characters returned through an external pin loop and through the internal loopback.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;

  typedef struct packed {
    logic loop;
    logic en;
    logic inv;
    logic nine;
    logic wake;
    logic idle_after_stop;
    logic par_en;
    logic par_odd;
  } ctrl_t;

  localparam int unsigned SAMPLES_PER_BIT = 16;

  function automatic logic [3:0] frame_len(input logic nine);
    return nine ? 4'd11 : 4'd10;
  endfunction

  function automatic logic [7:0] idle_limit(input logic nine);
    return nine ? 8'd176 : 8'd160;
  endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_t      cfg,
  input  logic       tick,
  input  logic       wr,
  input  logic [8:0] wdata,
  output logic       hold_full,
  output logic       busy,
  output logic       ser
);
  logic [8:0]  hold_q, hold_d;
  logic        full_q, full_d;
  logic        busy_q, busy_d;
  logic [10:0] shr_q, shr_d;
  logic [3:0]  left_q, left_d;
  logic [3:0]  sub_q, sub_d;
  logic [8:0]  pay;
  logic [10:0] frame;

  assign hold_full = full_q;
  assign busy      = busy_q;
  assign ser       = (cfg.en && busy_q) ? shr_q[0] : 1'b1;

  always_comb begin
    pay = hold_q;
    if (!cfg.nine) pay[8] = 1'b0;
    if (cfg.par_en) begin
      if (cfg.nine) pay[8] = (^hold_q[7:0]) ^ cfg.par_odd;
      else          pay[7] = (^hold_q[6:0]) ^ cfg.par_odd;
    end
    frame = cfg.nine ? {1'b1, pay[8:0], 1'b0} : {2'b11, pay[7:0], 1'b0};
  end

  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    busy_d = busy_q;
    shr_d  = shr_q;
    left_d = left_q;
    sub_d  = sub_q;
    if (!cfg.en) begin
      full_d = 1'b0;
      busy_d = 1'b0;
      sub_d  = '0;
      left_d = '0;
    end else begin
      if (wr && !full_q) begin
        full_d = 1'b1;
        hold_d = wdata;
      end
      if (!busy_q && full_q) begin
        busy_d = 1'b1;
        full_d = 1'b0;
        shr_d  = frame;
        left_d = frame_len(cfg.nine);
        sub_d  = '0;
      end else if (busy_q && tick) begin
        sub_d = sub_q + 4'd1;
        if (sub_q == 4'd15) begin
          shr_d  = {1'b1, shr_q[10:1]};
          left_d = left_q - 4'd1;
          if (left_q == 4'd1) busy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      shr_q  <= '1;
      left_q <= '0;
      sub_q  <= '0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      busy_q <= busy_d;
      shr_q  <= shr_d;
      left_q <= left_d;
      sub_q  <= sub_d;
    end
  end
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_t      cfg,
  input  logic       tick,
  input  logic       smp,
  output logic       valid,
  output logic [8:0] data,
  output logic       ferr,
  output logic       perr,
  output logic       amark,
  output logic       idle
);
  typedef enum logic {RX_WAIT, RX_FRAME} rx_st_e;

  rx_st_e     st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [3:0] idx_q, idx_d;
  logic       s7_q, s7_d, s8_q, s8_d;
  logic [8:0] buf_q, buf_d;
  logic       valid_q, valid_d;
  logic [8:0] data_q, data_d;
  logic       ferr_q, ferr_d, perr_q, perr_d, amark_q, amark_d;
  logic [7:0] icnt_q, icnt_d;
  logic       armed_q, armed_d;
  logic       idle_q, idle_d;
  logic       maj;
  logic [3:0] stop_idx;
  logic [7:0] thr;

  assign valid = valid_q;
  assign data  = data_q;
  assign ferr  = ferr_q;
  assign perr  = perr_q;
  assign amark = amark_q;
  assign idle  = idle_q;

  assign maj      = (s7_q & s8_q) | (s7_q & smp) | (s8_q & smp);
  assign stop_idx = cfg.nine ? 4'd10 : 4'd9;
  assign thr      = idle_limit(cfg.nine);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    s7_d    = s7_q;
    s8_d    = s8_q;
    buf_d   = buf_q;
    valid_d = 1'b0;
    data_d  = data_q;
    ferr_d  = ferr_q;
    perr_d  = perr_q;
    amark_d = amark_q;
    icnt_d  = icnt_q;
    armed_d = armed_q;
    idle_d  = 1'b0;
    if (!cfg.en) begin
      st_d    = RX_WAIT;
      cnt_d   = '0;
      idx_d   = '0;
      buf_d   = '0;
      icnt_d  = '0;
      armed_d = 1'b0;
    end else begin
      if (tick) begin
        if (st_q == RX_WAIT) begin
          if (!smp) begin
            st_d  = RX_FRAME;
            cnt_d = 4'd1;
            idx_d = '0;
            buf_d = '0;
          end
        end else begin
          cnt_d = cnt_q + 4'd1;
          if (cnt_q == 4'd15) idx_d = idx_q + 4'd1;
          case (cnt_q)
            4'd7: s7_d = smp;
            4'd8: s8_d = smp;
            4'd9: begin
              if (idx_q == 4'd0) begin
                if (maj) st_d = RX_WAIT;
              end else if (idx_q == stop_idx) begin
                st_d    = RX_WAIT;
                valid_d = 1'b1;
                data_d  = buf_q;
                ferr_d  = !maj;
                perr_d  = cfg.par_en && ((^buf_q) ^ cfg.par_odd);
                amark_d = cfg.nine && !cfg.par_en && cfg.wake && buf_q[8];
              end else begin
                for (int k = 0; k < 9; k++) begin
                  if (idx_q == 4'(k + 1)) buf_d[k] = maj;
                end
              end
            end
            default: ;
          endcase
        end
        if (!smp || (cfg.idle_after_stop && st_q == RX_FRAME)) icnt_d = '0;
        else if (icnt_q < thr) icnt_d = icnt_q + 8'd1;
      end
      if (armed_q && icnt_q >= thr) begin
        idle_d  = 1'b1;
        armed_d = 1'b0;
      end
      if (valid_d) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_WAIT;
      cnt_q   <= '0;
      idx_q   <= '0;
      s7_q    <= 1'b1;
      s8_q    <= 1'b1;
      buf_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      amark_q <= 1'b0;
      icnt_q  <= '0;
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      s7_q    <= s7_d;
      s8_q    <= s8_d;
      buf_q   <= buf_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      ferr_q  <= ferr_d;
      perr_q  <= perr_d;
      amark_q <= amark_d;
      icnt_q  <= icnt_d;
      armed_q <= armed_d;
      idle_q  <= idle_d;
    end
  end
endmodule

// File: rtl/uart_loop_xcvr.sv
module uart_loop_xcvr
  import uart_cfg_pkg::*;
#(
  parameter int unsigned OVS_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_wr,
  input  logic [8:0] tx_wdata,
  output logic       tx_empty,
  output logic       tx_done,
  output logic       tx_irq,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [8:0] rx_data,
  output logic       rx_frame_err,
  output logic       rx_par_err,
  output logic       rx_addr_mark,
  output logic       rx_idle
);
  ctrl_t      ctrl_q, ctrl_d;
  logic [1:0] sync_q, sync_d;
  logic       tick;
  logic       hold_full, tx_busy, tx_ser;
  logic       rx_in;

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr) ctrl_d = ctrl_t'(reg_wdata);
    sync_d = {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sync_q <= 2'b11;
    end else begin
      ctrl_q <= ctrl_d;
      sync_q <= sync_d;
    end
  end

  assign reg_rdata = ctrl_q;

  uart_tick_gen #(.DIV(OVS_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctrl_q.en),
    .tick (tick)
  );

  uart_tx_path u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (ctrl_q),
    .tick     (tick),
    .wr       (tx_wr),
    .wdata    (tx_wdata),
    .hold_full(hold_full),
    .busy     (tx_busy),
    .ser      (tx_ser)
  );

  assign rx_in = ctrl_q.loop ? tx_ser : sync_q[1];

  uart_rx_path u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .cfg  (ctrl_q),
    .tick (tick),
    .smp  (rx_in),
    .valid(rx_valid),
    .data (rx_data),
    .ferr (rx_frame_err),
    .perr (rx_par_err),
    .amark(rx_addr_mark),
    .idle (rx_idle)
  );

  assign txd      = (ctrl_q.loop ? 1'b1 : tx_ser) ^ ctrl_q.inv;
  assign tx_empty = !ctrl_q.en || !hold_full;
  assign tx_done  = !ctrl_q.en || (!hold_full && !tx_busy);
  assign tx_irq   = ctrl_q.en && !hold_full;
endmodule

// File: rtl/uart_loop_xcvr_chk.sv
module uart_loop_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       tx_empty,
  input logic       tx_done,
  input logic       tx_irq,
  input logic       txd,
  input logic       rx_valid
);
  assert_disabled_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[6] |-> (tx_empty && tx_done && !tx_irq));

  assert_disabled_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[6] |-> (txd == !reg_rdata[5]));

  assert_loop_pin_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] |-> (txd == !reg_rdata[5]));

  assert_done_means_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_empty);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind uart_loop_xcvr uart_loop_xcvr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_rdata(reg_rdata),
  .tx_empty (tx_empty),
  .tx_done  (tx_done),
  .tx_irq   (tx_irq),
  .txd      (txd),
  .rx_valid (rx_valid)
);

// File: tb/uart_loop_xcvr_test.sv
module uart_loop_xcvr_test;
  localparam int OVS = 4;
  localparam int BIT = 16 * OVS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_wr = 1'b0;
  logic [8:0] tx_wdata = '0;
  logic       tx_empty, tx_done, tx_irq, txd, rxd;
  logic       rx_valid, rx_frame_err, rx_par_err, rx_addr_mark, rx_idle;
  logic [8:0] rx_data;
  logic       ext_drive = 1'b0;
  logic       drv = 1'b1;
  bit         finished = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rx_cnt = 0;
  int idle_cnt = 0;
  int valid_time = 0;
  int idle_time = 0;
  logic [8:0] last_data = '0;
  logic last_ferr = 1'b0, last_perr = 1'b0, last_amark = 1'b0;

  always #10 clk = ~clk;

  assign rxd = ext_drive ? drv : txd;

  uart_loop_xcvr #(.OVS_DIV(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .tx_empty(tx_empty), .tx_done(tx_done), .tx_irq(tx_irq), .txd(txd),
    .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
    .rx_addr_mark(rx_addr_mark), .rx_idle(rx_idle)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) begin
      rx_cnt     <= rx_cnt + 1;
      valid_time <= cyc;
      last_data  <= rx_data;
      last_ferr  <= rx_frame_err;
      last_perr  <= rx_par_err;
      last_amark <= rx_addr_mark;
    end
    if (rx_idle) begin
      idle_cnt  <= idle_cnt + 1;
      idle_time <= cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_tx(input logic [8:0] d, input bit chk);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_wdata = d;
    @(negedge clk);
    tx_wr = 1'b0;
    if (chk) begin
      check(tx_empty == 1'b0, "R10 empty drops", tx_empty, 0);
      @(negedge clk);
      check(tx_empty == 1'b1 && tx_done == 1'b0, "R10 frame start flags",
            {tx_empty, tx_done}, 2'b10);
    end
  endtask

  function automatic logic [8:0] payload(input logic [8:0] d, input bit nine,
                                         input bit pen, input bit odd);
    logic [8:0] p;
    p = nine ? d : {1'b0, d[7:0]};
    if (pen) begin
      if (nine) p[8] = (^d[7:0]) ^ odd;
      else      p[7] = (^d[6:0]) ^ odd;
    end
    return p;
  endfunction

  function automatic logic [10:0] frame_of(input logic [8:0] p, input bit nine);
    return nine ? {1'b1, p, 1'b0} : {2'b11, p[7:0], 1'b0};
  endfunction

  task automatic capture(input int n, input bit inv, output logic [10:0] bits);
    int w;
    bits = '1;
    w = 0;
    while (txd !== inv && w < 3 * BIT) begin
      @(negedge clk);
      w++;
    end
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd ^ inv;
      repeat (BIT) @(negedge clk);
    end
  endtask

  task automatic wait_rx(input int prev);
    int w;
    w = 0;
    while (rx_cnt == prev && w < 3 * BIT) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic drive_bits(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      drv = bits[i];
      repeat (BIT) @(negedge clk);
    end
    drv = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] got, exp;
    logic [8:0] p;
    int prev, lows, d0, d1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 disabled flags
    check(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
    check(tx_empty && tx_done && !tx_irq && txd, "R2 disabled flags",
          {tx_empty, tx_done, tx_irq, txd}, 4'b1101);
    wr_ctrl(8'h9B);
    @(negedge clk);
    check(reg_rdata == 8'h9B, "R1 readback", reg_rdata, 8'h9B);
    wr_ctrl(8'h00);

    // R2: write while disabled is dropped
    prev = rx_cnt;
    send_tx(9'h055, 1'b0);
    wr_ctrl(8'h40);
    lows = 0;
    for (int i = 0; i < 2 * BIT; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    check(lows == 0 && tx_empty && rx_cnt == prev, "R2 dropped write",
          lows, 0);
    check(tx_irq == 1'b1, "R10 irq when enabled and empty", tx_irq, 1);

    // R3 R4 R5 R8: sweep over length, parity, type, data through pin loop
    for (int cfg = 0; cfg < 8; cfg++) begin
      bit nine, pen, odd;
      nine = cfg[2];
      pen  = cfg[1];
      odd  = cfg[0];
      wr_ctrl(8'h40 | (8'(nine) << 4) | (8'(pen) << 1) | 8'(odd));
      for (int k = 0; k < 4; k++) begin
        logic [8:0] d;
        d = (k == 0) ? 9'h000 : (k == 1) ? 9'h1FF : (k == 2) ? 9'h0A5 : 9'h15A;
        p = payload(d, nine, pen, odd);
        exp = frame_of(p, nine);
        prev = rx_cnt;
        send_tx(d, 1'b1);
        capture(nine ? 11 : 10, 1'b0, got);
        if (!nine) got[10] = 1'b1;
        check(got == exp, nine ? "R4 R5 frame bits" : "R3 R5 frame bits", got, exp);
        wait_rx(prev);
        check(rx_cnt == prev + 1 && last_data == p && !last_ferr && !last_perr,
              "R8 received character", {last_ferr, last_perr, last_data}, p);
        repeat (BIT) @(negedge clk);
        check(tx_done == 1'b1, "R10 done after stop", tx_done, 1);
      end
    end

    // R11 address mark
    wr_ctrl(8'h58);
    prev = rx_cnt;
    send_tx(9'h13C, 1'b0);
    capture(11, 1'b0, got);
    wait_rx(prev);
    check(last_amark == 1'b1, "R11 mark set", last_amark, 1);
    prev = rx_cnt;
    send_tx(9'h03C, 1'b0);
    capture(11, 1'b0, got);
    wait_rx(prev);
    check(last_amark == 1'b0, "R11 mark clear bit8=0", last_amark, 0);
    wr_ctrl(8'h50);
    prev = rx_cnt;
    send_tx(9'h13C, 1'b0);
    capture(11, 1'b0, got);
    wait_rx(prev);
    check(last_amark == 1'b0, "R11 mark clear when disabled", last_amark, 0);
    repeat (2 * BIT) @(negedge clk);

    // R6 inversion
    ext_drive = 1'b1;
    drv = 1'b1;
    wr_ctrl(8'h20);
    @(negedge clk);
    check(txd == 1'b0, "R6 disabled idle inverted", txd, 0);
    wr_ctrl(8'h60);
    @(negedge clk);
    check(txd == 1'b0, "R6 enabled idle inverted", txd, 0);
    send_tx(9'h035, 1'b0);
    capture(10, 1'b1, got);
    got[10] = 1'b1;
    exp = frame_of(9'h035, 1'b0);
    check(got == exp, "R6 inverted frame", got, exp);
    repeat (BIT) @(negedge clk);
    check(txd == 1'b0 && tx_done, "R6 idle after frame", txd, 0);

    // R7 loopback, with and without inversion
    for (int iv = 0; iv < 2; iv++) begin
      wr_ctrl(iv ? 8'hE2 : 8'hC2);
      drv = 1'b0;
      prev = rx_cnt;
      lows = 0;
      send_tx(9'h0C3, 1'b0);
      for (int i = 0; i < 12 * BIT; i++) begin
        @(negedge clk);
        if (txd !== 1'(iv == 0)) lows++;
      end
      p = payload(9'h0C3, 1'b0, 1'b1, 1'b0);
      check(lows == 0, "R7 txd held idle", lows, 0);
      check(rx_cnt == prev + 1 && last_data == p && !last_perr && !last_ferr,
            "R7 loop data", last_data, p);
      drv = 1'b1;
    end

    // R8 error detection through the pin
    wr_ctrl(8'h42);
    repeat (2 * BIT) @(negedge clk);
    prev = rx_cnt;
    p = 9'h003;                         // even parity of 0000011 is 0; send 1
    exp = {2'b11, 8'h83, 1'b0};
    drive_bits(exp, 10);
    wait_rx(prev);
    check(last_perr == 1'b1 && !last_ferr, "R8 parity error", last_perr, 1);
    prev = rx_cnt;
    exp = {2'b11, 8'h03, 1'b0};
    drive_bits(exp, 10);
    wait_rx(prev);
    check(last_perr == 1'b0 && last_data == 9'h003, "R8 good parity", last_data, p);
    prev = rx_cnt;
    exp = {2'b10, 8'h03, 1'b0};
    drive_bits(exp, 10);
    wait_rx(prev);
    check(last_ferr == 1'b1, "R8 framing error", last_ferr, 1);
    repeat (12 * BIT) @(negedge clk);

    // R9 glitch rejection
    prev = rx_cnt;
    drv = 1'b0;
    repeat (2 * OVS) @(negedge clk);
    drv = 1'b1;
    repeat (24 * BIT) @(negedge clk);
    check(rx_cnt == prev, "R9 glitch rejected", rx_cnt - prev, 0);

    // R12 idle detection in both modes, character 0xFF
    wr_ctrl(8'h40);
    repeat (12 * BIT) @(negedge clk);
    prev = idle_cnt;
    drive_bits({2'b11, 8'hFF, 1'b0}, 10);
    for (int w = 0; w < 20 * BIT && idle_cnt == prev; w++) @(negedge clk);
    d0 = idle_time - valid_time;
    check(idle_cnt == prev + 1 && d0 > 0 && d0 < 3 * BIT, "R12 idle counts in-frame ones",
          d0, 3 * BIT);
    wr_ctrl(8'h44);
    repeat (12 * BIT) @(negedge clk);
    prev = idle_cnt;
    drive_bits({2'b11, 8'hFF, 1'b0}, 10);
    for (int w = 0; w < 20 * BIT && idle_cnt == prev; w++) @(negedge clk);
    d1 = idle_time - valid_time;
    check(idle_cnt == prev + 1 && d1 >= 10 * BIT - 2 * OVS && d1 <= 10 * BIT + 2 * OVS,
          "R12 idle after stop", d1, 10 * BIT);
    repeat (12 * BIT) @(negedge clk);
    check(idle_cnt == prev + 1, "R12 single idle pulse", idle_cnt, prev + 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule